// File: doc/BRIEF.md
# Sixteen-bit ALU with Boolean Comparisons

A purely combinational arithmetic logic unit for a small general-purpose datapath. It takes two 16-bit operands and a 4-bit operation code. Operand B is either a register value or a sign-extended immediate, chosen upstream. It returns a 16-bit result and a zero flag.

The operation set covers four bitwise functions, modular add and subtract, and two shifts by a signed amount. One shift fills with the sign bit and the other with zeros, which gives multiply and divide by powers of two for integers and for naturals. Comparisons come in signed and unsigned forms and deliver a full data word holding 0 or 1. There is also a pass-through of B and a move-high that loads a byte into the upper half of the word.

The zero flag is meant for the sequencing logic: after a comparison it reads as "condition false", and after arithmetic it reads as "result is zero".

Top module: `alu16_core`

## Requirements
- R1: Code 0 returns A AND B, code 1 returns A OR B, code 2 returns A XOR B, and code 3 returns the bitwise complement of A (B unused).
- R2: Code 4 returns (A + B) mod 2^16 and code 5 returns (A - B) mod 2^16; carries and borrows out of bit 15 are dropped.
- R3: Code 7 is a logical shift of A by the two's-complement value k held in B[4:0], range -16..15. For k >= 0 it shifts left by k; for k < 0 it shifts right by -k. Vacated bits become 0 and B[15:5] has no effect.
- R4: Code 6 is an arithmetic shift of A by the same signed amount. Left shifts fill with 0 and right shifts fill with A[15], so a shift by -16 yields 16'hFFFF or 16'h0000.
- R5: Code 8 returns 1 when A < B as two's-complement numbers, and code 9 returns 1 when A <= B signed; otherwise each returns 0.
- R6: Code 11 returns 1 when A < B as unsigned numbers, and code 12 returns 1 when A <= B unsigned; otherwise each returns 0.
- R7: Code 10 returns 1 when A equals B, else 0. Every comparison code (8..12) drives bits 15:1 of the result to 0.
- R8: Code 13 returns B unchanged.
- R9: Code 14 returns {B[7:0], A[7:0]}.
- R10: The zero flag is 1 exactly when the 16-bit result is 16'h0000, for every code.
- R11: Code 15 is reserved and returns 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code (see R1..R11) |
| a | input | 16 | Operand A |
| b | input | 16 | Operand B, register or immediate |
| y | output | 16 | Result word |
| zero | output | 1 | High when the result is zero |

## Verification
The bench builds the block with its default width of 16. That width puts the signed shift field at 5 bits, so the bench can reach the extreme amounts +15 and -16 and the signed/unsigned disagreement at the 16'h7FFF/16'h8000 boundary.

Directed vectors hit those boundaries, along with add wrap to zero, upper B bits beside the shift field, and the reserved code. A long pseudo-random walk then sweeps all sixteen codes against a bit-serial reference model.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    OP_AND    = 4'd0,
    OP_OR     = 4'd1,
    OP_XOR    = 4'd2,
    OP_NOT    = 4'd3,
    OP_ADD    = 4'd4,
    OP_SUB    = 4'd5,
    OP_SHA    = 4'd6,
    OP_SHL    = 4'd7,
    OP_LT     = 4'd8,
    OP_LE     = 4'd9,
    OP_EQ     = 4'd10,
    OP_LTU    = 4'd11,
    OP_LEU    = 4'd12,
    OP_MOV    = 4'd13,
    OP_MOVHI  = 4'd14,
    OP_RSVD   = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu16_logic.sv
module alu16_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  // one bitwise cell per bit; sel 0:and 1:or 2:xor 3:not a
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel)
        2'd0:    y[i] = a[i] & b[i];
        2'd1:    y[i] = a[i] | b[i];
        2'd2:    y[i] = a[i] ^ b[i];
        default: y[i] = ~a[i];
      endcase
    end
  end
endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  logic [W-1:0] b_eff;
  assign b_eff = sub ? ~b : b;
  // single adder, subtract as a + ~b + 1
  assign y = a + b_eff + {{(W-1){1'b0}}, sub};
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
  parameter int W   = 16,
  parameter int SAW = $clog2(W) + 1
) (
  input  logic [W-1:0]   a,
  input  logic [SAW-1:0] amt,
  input  logic           arith,
  output logic [W-1:0]   y
);
  logic               neg;
  logic [SAW-1:0]     mag;
  logic [W-1:0]       shl;
  logic [W-1:0]       shr_log;
  logic signed [W-1:0] a_s;
  logic signed [W-1:0] shr_ari;

  assign neg     = amt[SAW-1];
  assign mag     = neg ? (~amt + {{(SAW-1){1'b0}}, 1'b1}) : amt;
  assign a_s     = a;
  assign shl     = a << mag;
  assign shr_log = a >> mag;
  assign shr_ari = a_s >>> mag;

  always_comb begin
    if (!neg)       y = shl;
    else if (arith) y = shr_ari;
    else            y = shr_log;
  end
endmodule

// File: rtl/alu16_cmp.sv
module alu16_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt_s,
  output logic         lt_u,
  output logic         eq
);
  logic [W:0] diff;
  // borrow of a - b gives unsigned less-than
  assign diff = {1'b0, a} - {1'b0, b};
  assign lt_u = diff[W];
  assign eq   = (a == b);
  // signed: operands of opposite sign decide by a's sign
  assign lt_s = (a[W-1] ^ b[W-1]) ? a[W-1] : diff[W];
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  localparam int SAW  = $clog2(W) + 1;
  localparam int HALF = W / 2;

  alu_op_e      op_e;
  logic [W-1:0] log_y, as_y, sh_y;
  logic         lt_s, lt_u, eq;
  logic         cmp_bit;

  assign op_e = alu_op_e'(op);

  alu16_logic #(.W(W)) u_logic (
    .a(a), .b(b), .sel(op[1:0]), .y(log_y)
  );

  alu16_addsub #(.W(W)) u_addsub (
    .a(a), .b(b), .sub(op_e == OP_SUB), .y(as_y)
  );

  alu16_shift #(.W(W), .SAW(SAW)) u_shift (
    .a(a), .amt(b[SAW-1:0]), .arith(op_e == OP_SHA), .y(sh_y)
  );

  alu16_cmp #(.W(W)) u_cmp (
    .a(a), .b(b), .lt_s(lt_s), .lt_u(lt_u), .eq(eq)
  );

  always_comb begin
    unique case (op_e)
      OP_LT:   cmp_bit = lt_s;
      OP_LE:   cmp_bit = lt_s | eq;
      OP_LTU:  cmp_bit = lt_u;
      OP_LEU:  cmp_bit = lt_u | eq;
      default: cmp_bit = eq;
    endcase
  end

  always_comb begin
    unique case (op_e)
      OP_AND, OP_OR, OP_XOR, OP_NOT:         y = log_y;
      OP_ADD, OP_SUB:                        y = as_y;
      OP_SHA, OP_SHL:                        y = sh_y;
      OP_LT, OP_LE, OP_EQ, OP_LTU, OP_LEU:   y = {{(W-1){1'b0}}, cmp_bit};
      OP_MOV:                                y = b;
      OP_MOVHI:                              y = {b[HALF-1:0], a[HALF-1:0]};
      default:                               y = '0;
    endcase
  end

  assign zero = ~|y;
endmodule

// File: rtl/alu16_checker.sv
module alu16_checker #(
  parameter int W = 16
) (
  input logic [3:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] y,
  input logic         zero
);
  localparam int HALF = W / 2;

  always_comb begin
    if (op == 4'd3)
      a_r1_not_complement: assert ((y ^ a) == {W{1'b1}});
    if (op == 4'd4)
      a_r2_add_inverse: assert (W'(y - b) == a);
    if (op == 4'd5)
      a_r2_sub_inverse: assert (W'(y + b) == a);
    if (op >= 4'd8 && op <= 4'd12)
      a_r7_cmp_bool: assert (y[W-1:1] == '0);
    if (op == 4'd10 && a == b)
      a_r10_eq_not_zero: assert (!zero);
    if (op == 4'd13)
      a_r8_mov_pass: assert (y == b);
    if (op == 4'd14)
      a_r9_low_byte: assert (y[HALF-1:0] == a[HALF-1:0]);
    if (op == 4'd15)
      a_r11_reserved: assert (zero);
  end
endmodule

bind alu16_core alu16_checker #(.W(W)) u_chk (
  .op(op), .a(a), .b(b), .y(y), .zero(zero)
);

// File: tb/tb_alu16_core.sv
module tb_alu16_core;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op;
  logic [15:0] a, b;
  logic [15:0] y;
  logic        zero;
  int          total, bad;
  bit          done;

  alu16_core dut (.op(op), .a(a), .b(b), .y(y), .zero(zero));

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // {op, a, b, expected}
  localparam int NV = 24;
  localparam logic [51:0] VEC [NV] = '{
    {4'd0,  16'hF0F0, 16'hFF00, 16'hF000},
    {4'd1,  16'hF0F0, 16'h0F00, 16'hFFF0},
    {4'd2,  16'hAAAA, 16'hFFFF, 16'h5555},
    {4'd3,  16'h1234, 16'h5A5A, 16'hEDCB},
    {4'd4,  16'hFFFF, 16'h0001, 16'h0000},
    {4'd4,  16'h1234, 16'h1111, 16'h2345},
    {4'd5,  16'h0000, 16'h0001, 16'hFFFF},
    {4'd6,  16'h8001, 16'h0001, 16'h0002},
    {4'd6,  16'h8000, 16'h001F, 16'hC000},
    {4'd6,  16'h8000, 16'h0010, 16'hFFFF},
    {4'd7,  16'h8000, 16'h0010, 16'h0000},
    {4'd7,  16'h8000, 16'h001F, 16'h4000},
    {4'd7,  16'h0001, 16'h000F, 16'h8000},
    {4'd7,  16'h0001, 16'hFFE1, 16'h0002},
    {4'd8,  16'hFFFF, 16'h0001, 16'h0001},
    {4'd11, 16'hFFFF, 16'h0001, 16'h0000},
    {4'd9,  16'h0005, 16'h0005, 16'h0001},
    {4'd12, 16'h8000, 16'h7FFF, 16'h0000},
    {4'd10, 16'h1234, 16'h1234, 16'h0001},
    {4'd10, 16'h1234, 16'h1235, 16'h0000},
    {4'd13, 16'h0000, 16'hBEEF, 16'hBEEF},
    {4'd14, 16'h1234, 16'h00AB, 16'hAB34},
    {4'd15, 16'hFFFF, 16'hFFFF, 16'h0000},
    {4'd8,  16'h7FFF, 16'h8000, 16'h0000}
  };

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1, 4'd2, 4'd3: return "R1";
      4'd4, 4'd5:             return "R2";
      4'd6:                   return "R4";
      4'd7:                   return "R3";
      4'd8, 4'd9:             return "R5";
      4'd10:                  return "R7";
      4'd11, 4'd12:           return "R6";
      4'd13:                  return "R8";
      4'd14:                  return "R9";
      default:                return "R11";
    endcase
  endfunction

  // bit-serial reference model
  function automatic logic [15:0] ref_alu(input logic [3:0] o,
                                          input logic [15:0] x, input logic [15:0] z);
    logic [15:0] r;
    int k;
    k = z[4] ? int'(z[4:0]) - 32 : int'(z[4:0]);
    r = 16'h0000;
    case (o)
      4'd0:  r = x & z;
      4'd1:  r = x | z;
      4'd2:  r = x ^ z;
      4'd3:  r = ~x;
      4'd4:  r = x + z;
      4'd5:  r = x - z;
      4'd6, 4'd7: begin
        r = x;
        if (k >= 0) for (int i = 0; i < k; i++) r = {r[14:0], 1'b0};
        else for (int i = 0; i < -k; i++) r = {(o == 4'd6) ? r[15] : 1'b0, r[15:1]};
      end
      4'd8:  r = ($signed(x) <  $signed(z)) ? 16'd1 : 16'd0;
      4'd9:  r = ($signed(x) <= $signed(z)) ? 16'd1 : 16'd0;
      4'd10: r = (x == z) ? 16'd1 : 16'd0;
      4'd11: r = (x <  z) ? 16'd1 : 16'd0;
      4'd12: r = (x <= z) ? 16'd1 : 16'd0;
      4'd13: r = z;
      4'd14: r = {z[7:0], x[7:0]};
      default: r = 16'h0000;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [15:0] x, input logic [15:0] z,
                       input logic [15:0] exp);
    @(negedge clk);
    op = o; a = x; b = z;
    #1;
    chk(req_of(o), $sformatf("op=%0d a=%h b=%h", o, x, z), y, exp);
    chk("R10", $sformatf("zero op=%0d", o), {15'd0, zero}, {15'd0, exp == 16'h0000});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; op = 4'd0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: all-zero inputs give a zero AND result
    chk("R1", "reset result", y, 16'h0000);
    chk("R10", "reset zero", {15'd0, zero}, 16'h0001);

    for (int i = 0; i < NV; i++)
      apply(VEC[i][51:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);

    // R3: upper B bits beside the shift field have no effect
    apply(4'd7, 16'h00F0, 16'hAA1C, 16'h000F);
    apply(4'd7, 16'h00F0, 16'h001C, 16'h000F);
    // R4: left arithmetic shift fills with zeros
    apply(4'd6, 16'hFFFF, 16'h0004, 16'hFFF0);
    // R4: positive value shifted right by 16 becomes zero
    apply(4'd6, 16'h7FFF, 16'h0010, 16'h0000);
    // R5/R6 disagree at sign boundary
    apply(4'd9, 16'h8000, 16'h7FFF, 16'h0001);
    apply(4'd11, 16'h7FFF, 16'h8000, 16'h0001);
    // R2 wrap on subtract to zero
    apply(4'd5, 16'h8000, 16'h8000, 16'h0000);

    s = 32'h1F2E3D4C;
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] x, z;
      logic [3:0]  o;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      x = s[15:0];
      z = s[31:16];
      o = 4'(i);
      if (i % 7 == 0) z = x;
      apply(o, x, z, ref_alu(o, x, z));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule